// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block runs the descriptor side of one DMA channel. Software writes a 64-bit list pointer in two 32-bit halves and pulses start. The block then reads a ten-word descriptor from memory through a simple word-read port. It unpacks the source address, the destination address, the item count and the two control words. It offers one block command to a data mover over a valid/ready handshake and waits for the mover to report that the block is finished.

When the finished descriptor is not marked last, the block follows its next pointer and repeats. When it is marked last, the block raises a one-cycle done pulse and goes idle. A descriptor whose valid flag is clear is never issued. The block raises a one-cycle error pulse instead and stops. A suspend input holds the block after a descriptor has been fetched, so no new command is offered until the input is released.

Top module: `lli_walker`

## Requirements
- R1: After reset, busy, mem_req, cmd_valid, xfer_done and err are all 0.
- R2: lp_wr with lp_hi=0 loads pointer bits 31:0 and with lp_hi=1 loads bits 63:32. Start reads the descriptor as ten words at addresses {ptr[63:6],6'b0}+0x00 up to +0x24, rising by 4. Pointer bit 0 appears on mem_sel throughout the fetch.
- R3: While mem_req is high, mem_addr and mem_sel do not change until mem_rvalid returns a word.
- R4: The descriptor words are laid out as follows: 0-1 hold the source, 2-3 the destination, 4 the stored count, 5 is unused, 6-7 the next pointer, 8 the low control word and 9 the high control word, each pair low word first. cmd_items equals stored count plus one, 33 bits wide, so 0xFFFFFFFF gives 2^32.
- R5: cmd_ctl_lo and cmd_ctl_hi equal descriptor words 8 and 9 bit for bit.
- R6: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and every command field stays stable.
- R7: If bit 31 (valid) of word 9 is 0, no command is issued for that descriptor. err pulses for one cycle and busy drops in the same cycle.
- R8: After blk_done for a descriptor whose word-9 bit 30 (last) is 1, xfer_done pulses for one cycle with busy low, and no further read is made. Otherwise the next pointer is fetched, and its bit 0 is the new mem_sel.
- R9: While suspend is high, no new command is offered. The fetched descriptor is issued once suspend falls.
- R10: start and pointer writes are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lp_wr | input | 1 | List-pointer half write strobe |
| lp_hi | input | 1 | Selects the upper (1) or lower (0) pointer half |
| lp_wdata | input | 32 | Pointer half data |
| start | input | 1 | Begin walking the list at the pointer |
| suspend | input | 1 | Hold before issuing the next command |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 64 | Word read byte address |
| mem_sel | output | 1 | Master port select for the read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| cmd_valid | output | 1 | Block command offered |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_src | output | 64 | Block source address |
| cmd_dst | output | 64 | Block destination address |
| cmd_items | output | 33 | Number of items in the block |
| cmd_ctl_lo | output | 32 | Low control word, unchanged |
| cmd_ctl_hi | output | 32 | High control word, unchanged |
| blk_done | input | 1 | Mover finished the current block |
| busy | output | 1 | Walk in progress |
| xfer_done | output | 1 | One-cycle pulse when the list ends |
| err | output | 1 | One-cycle pulse on an invalid descriptor |

## Verification
The bench feeds a pointer with junk in bits 5:1, so a design that forgot the alignment mask would read from the wrong words. A stored count of all ones catches a 32-bit count adder, which would issue zero items. An unlinked pointer after a last descriptor catches a walker that keeps going. A second descriptor with its valid bit clear catches a design that issues garbage or hangs instead of pulsing err. Other tests stall the mover's ready line, assert suspend, and issue a second start and a pointer rewrite in mid-walk. These expose a dropped valid, a command issued under suspend, and a restart or a corrupted pointer.

// File: rtl/lli_walker.sv
module lli_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_wr,
  input  logic        lp_hi,
  input  logic [31:0] lp_wdata,
  input  logic        start,
  input  logic        suspend,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic        mem_sel,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [63:0] cmd_src,
  output logic [63:0] cmd_dst,
  output logic [32:0] cmd_items,
  output logic [31:0] cmd_ctl_lo,
  output logic [31:0] cmd_ctl_hi,
  input  logic        blk_done,
  output logic        busy,
  output logic        xfer_done,
  output logic        err
);
  localparam int LAST_WORD = 9;
  localparam int VLD_BIT   = 31;
  localparam int END_BIT   = 30;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_HOLD, S_ISSUE, S_WAIT} st_t;
  st_t st_q;

  logic [63:0] lp_q, cur_q, src_q, dst_q, nxt_q;
  logic [31:0] cnt_q, clo_q, chi_q;
  logic [3:0]  widx_q;

  assign busy       = (st_q != S_IDLE);
  assign mem_req    = (st_q == S_FETCH);
  assign mem_addr   = {cur_q[63:6], widx_q, 2'b00};
  assign mem_sel    = cur_q[0];
  assign cmd_valid  = (st_q == S_ISSUE);
  assign cmd_src    = src_q;
  assign cmd_dst    = dst_q;
  assign cmd_items  = {1'b0, cnt_q} + 33'd1;
  assign cmd_ctl_lo = clo_q;
  assign cmd_ctl_hi = chi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
    end else if (lp_wr && st_q == S_IDLE) begin
      if (lp_hi) lp_q[63:32] <= lp_wdata;
      else       lp_q[31:0]  <= lp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; nxt_q <= '0;
      cnt_q <= '0; clo_q <= '0; chi_q <= '0;
    end else if (st_q == S_FETCH && mem_rvalid) begin
      case (widx_q)
        4'd0: src_q[31:0]  <= mem_rdata;
        4'd1: src_q[63:32] <= mem_rdata;
        4'd2: dst_q[31:0]  <= mem_rdata;
        4'd3: dst_q[63:32] <= mem_rdata;
        4'd4: cnt_q        <= mem_rdata;
        4'd6: nxt_q[31:0]  <= mem_rdata;
        4'd7: nxt_q[63:32] <= mem_rdata;
        4'd8: clo_q        <= mem_rdata;
        4'd9: chi_q        <= mem_rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      widx_q    <= '0;
      xfer_done <= 1'b0;
      err       <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      err       <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          cur_q  <= lp_q;
          widx_q <= '0;
          st_q   <= S_FETCH;
        end
        S_FETCH: if (mem_rvalid) begin
          if (widx_q == 4'(LAST_WORD)) begin
            widx_q <= '0;
            if (!mem_rdata[VLD_BIT]) begin
              err  <= 1'b1;
              st_q <= S_IDLE;
            end else begin
              st_q <= S_HOLD;
            end
          end else begin
            widx_q <= widx_q + 4'd1;
          end
        end
        S_HOLD:  if (!suspend) st_q <= S_ISSUE;
        S_ISSUE: if (cmd_ready) st_q <= S_WAIT;
        S_WAIT: if (blk_done) begin
          if (chi_q[END_BIT]) begin
            xfer_done <= 1'b1;
            st_q      <= S_IDLE;
          end else begin
            cur_q  <= nxt_q;
            widx_q <= '0;
            st_q   <= S_FETCH;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lli_walker_chk.sv
module lli_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        suspend,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_sel,
  input logic        mem_rvalid,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [63:0] cmd_src,
  input logic [63:0] cmd_dst,
  input logic [32:0] cmd_items,
  input logic [31:0] cmd_ctl_lo,
  input logic [31:0] cmd_ctl_hi,
  input logic        busy,
  input logic        xfer_done,
  input logic        err
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !cmd_valid));

  p_word_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && mem_addr[5:2] <= 4'd9));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_sel)));

  p_items_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_items != 33'd0));

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst)
      && $stable(cmd_items) && $stable(cmd_ctl_lo) && $stable(cmd_ctl_hi)));

  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done || err) |-> !busy);

  p_end_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && err));

  p_no_issue_suspended_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !$past(suspend));
endmodule

bind lli_walker lli_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .suspend(suspend),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_rvalid(mem_rvalid),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
  .cmd_items(cmd_items), .cmd_ctl_lo(cmd_ctl_lo), .cmd_ctl_hi(cmd_ctl_hi),
  .busy(busy), .xfer_done(xfer_done), .err(err)
);

// File: tb/lli_walker_test.sv
module lli_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_wr = 1'b0, lp_hi = 1'b0, start = 1'b0, suspend = 1'b0;
  logic [31:0] lp_wdata = '0;
  logic        mem_req, mem_sel, cmd_valid, busy, xfer_done, err;
  logic [63:0] mem_addr, cmd_src, cmd_dst;
  logic [32:0] cmd_items;
  logic [31:0] cmd_ctl_lo, cmd_ctl_hi;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        cmd_ready = 1'b0;
  logic        blk_done = 1'b0;

  localparam logic [31:0] VLD = 32'h8000_0000;
  localparam logic [31:0] LST = 32'h4000_0000;

  always #10 clk = ~clk;

  lli_walker uut (.*);

  logic [31:0] mem [0:255];
  logic [63:0] a_log [0:63];
  logic        s_log [0:63];
  int          a_n = 0;
  logic [63:0] c_src [0:7];
  logic [32:0] c_items [0:7];
  logic [31:0] c_lo [0:7], c_hi [0:7];
  int          c_n = 0, n_done = 0, n_err = 0, pend = 0;
  int          total = 0, bad = 0, cyc = 0;

  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= mem[mem_addr[9:2]];
    if (mem_req && !mem_rvalid && a_n < 64) begin
      a_log[a_n] <= mem_addr;
      s_log[a_n] <= mem_sel;
      a_n <= a_n + 1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (xfer_done) n_done++;
    if (err) n_err++;
    blk_done = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) blk_done = 1'b1;
    end
    if (rst_n && cmd_valid && cmd_ready && c_n < 8) begin
      c_src[c_n] = cmd_src; c_items[c_n] = cmd_items;
      c_lo[c_n] = cmd_ctl_lo; c_hi[c_n] = cmd_ctl_hi;
      c_n++;
      pend = 3;
    end
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic put_desc(input int a, input logic [63:0] s, input logic [63:0] d,
                          input logic [31:0] c, input logic [63:0] nx,
                          input logic [31:0] lo, input logic [31:0] hi);
    mem[a/4+0] = s[31:0];  mem[a/4+1] = s[63:32];
    mem[a/4+2] = d[31:0];  mem[a/4+3] = d[63:32];
    mem[a/4+4] = c;        mem[a/4+5] = 32'hDEAD_BEEF;
    mem[a/4+6] = nx[31:0]; mem[a/4+7] = nx[63:32];
    mem[a/4+8] = lo;       mem[a/4+9] = hi;
  endtask

  task automatic set_ptr(input logic [31:0] hi, input logic [31:0] lo);
    lp_wr = 1'b1; lp_hi = 1'b0; lp_wdata = lo; step();
    lp_hi = 1'b1; lp_wdata = hi; step();
    lp_wr = 1'b0; lp_hi = 1'b0;
  endtask

  task automatic go();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic clr();
    step();
    a_n = 0; c_n = 0; n_done = 0; n_err = 0;
  endtask

  task automatic wait_idle(input string tag);
    int k = 0;
    step();
    while (busy && k < 2000) begin step(); k++; end
    step(2);
    chk(!busy, tag, 64'(busy), 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req && !cmd_valid && !xfer_done && !err, "R1 reset outputs",
        {59'd0, busy, mem_req, cmd_valid, xfer_done, err}, 64'd0);
  endtask

  task automatic t_single();
    clr();
    cmd_ready = 1'b1;
    put_desc(32'h40, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 32'd15, 64'h0,
             32'h0001_2345, VLD | LST | 32'h0012_3456);
    set_ptr(32'h0, 32'h7E);
    go();
    wait_idle("R8 single idle");
    chk(a_n == 10, "R2 word count", 64'(a_n), 64'd10);
    for (int i = 0; i < 10; i++)
      chk(a_log[i] == 64'h40 + 64'(4*i) && s_log[i] == 1'b0, "R2 word address", a_log[i], 64'h40 + 64'(4*i));
    chk(c_n == 1, "R8 one command", 64'(c_n), 64'd1);
    chk(c_src[0] == 64'h1111_2222_3333_4444, "R4 source", c_src[0], 64'h1111_2222_3333_4444);
    chk(c_items[0] == 33'd16, "R4 items", 64'(c_items[0]), 64'd16);
    chk(c_lo[0] == 32'h0001_2345, "R5 ctl lo", 64'(c_lo[0]), 64'h0001_2345);
    chk(c_hi[0] == (VLD | LST | 32'h0012_3456), "R5 ctl hi", 64'(c_hi[0]), 64'(VLD | LST | 32'h0012_3456));
    chk(n_done == 1 && n_err == 0, "R8 done pulse", 64'(n_done), 64'd1);
  endtask

  task automatic t_chain();
    int k = 0;
    clr();
    cmd_ready = 1'b0;
    put_desc(32'h80, 64'hA0, 64'hB0, 32'hFFFF_FFFF, 64'hC1, 32'h11, VLD);
    put_desc(32'hC0, 64'hA1, 64'hB1, 32'd0, 64'h100, 32'h22, VLD | 32'h0000_8040);
    put_desc(32'h100, 64'hA2, 64'hB2, 32'd7, 64'h300, 32'h33, VLD | LST);
    mem[32'h300/4 + 9] = VLD;
    set_ptr(32'h0, 32'h80);
    go();
    while (!cmd_valid && k < 200) begin step(); k++; end
    step(5);
    chk(cmd_valid && cmd_src == 64'hA0, "R6 held offer", cmd_src, 64'hA0);
    chk(cmd_dst == 64'hB0, "R4 destination", cmd_dst, 64'hB0);
    cmd_ready = 1'b1;
    wait_idle("R8 chain idle");
    chk(c_n == 3, "R8 chain commands", 64'(c_n), 64'd3);
    chk(c_items[0] == 33'h1_0000_0000, "R4 max items", 64'(c_items[0]), 64'h1_0000_0000);
    chk(c_items[1] == 33'd1 && c_src[1] == 64'hA1, "R4 min items", 64'(c_items[1]), 64'd1);
    chk(c_hi[1] == (VLD | 32'h0000_8040), "R5 burst override passthrough", 64'(c_hi[1]), 64'(VLD | 32'h0000_8040));
    chk(c_items[2] == 33'd8 && c_src[2] == 64'hA2, "R8 third block", 64'(c_items[2]), 64'd8);
    chk(a_n == 30, "R8 no read past last", 64'(a_n), 64'd30);
    chk(a_log[10] == 64'hC0 && s_log[10] == 1'b1 && s_log[19] == 1'b1, "R8 master select follows link",
        a_log[10], 64'hC0);
    chk(a_log[20] == 64'h100 && s_log[20] == 1'b0, "R8 third fetch", a_log[20], 64'h100);
    chk(n_done == 1, "R8 chain done", 64'(n_done), 64'd1);
  endtask

  task automatic t_invalid();
    clr();
    cmd_ready = 1'b1;
    put_desc(32'h140, 64'hC0DE, 64'hD0, 32'd3, 64'h180, 32'h0, VLD);
    put_desc(32'h180, 64'hBAD, 64'hBAD, 32'd3, 64'h0, 32'h0, LST);
    set_ptr(32'h0, 32'h140);
    go();
    wait_idle("R7 idle after error");
    chk(c_n == 1, "R7 invalid not issued", 64'(c_n), 64'd1);
    chk(n_err == 1 && n_done == 0, "R7 error pulse", 64'(n_err), 64'd1);
    chk(a_n == 20, "R7 reads", 64'(a_n), 64'd20);
  endtask

  task automatic t_suspend();
    int k = 0;
    clr();
    cmd_ready = 1'b1;
    put_desc(32'h1C0, 64'hE0, 64'hF0, 32'd2, 64'h200, 32'h0, VLD);
    put_desc(32'h200, 64'hE1, 64'hF1, 32'd2, 64'h0, 32'h0, VLD | LST);
    set_ptr(32'h0, 32'h1C0);
    suspend = 1'b1;
    go();
    step(40);
    chk(a_n == 10 && c_n == 0 && !cmd_valid && busy, "R9 held before first block", 64'(c_n), 64'd0);
    suspend = 1'b0;
    while (c_n < 1 && k < 200) begin step(); k++; end
    suspend = 1'b1;
    step(60);
    chk(c_n == 1 && a_n == 20 && busy, "R9 held between blocks", 64'(c_n), 64'd1);
    suspend = 1'b0;
    wait_idle("R9 resume idle");
    chk(c_n == 2 && n_done == 1, "R9 resumed", 64'(c_n), 64'd2);
  endtask

  task automatic t_busy_ignore();
    clr();
    cmd_ready = 1'b0;
    set_ptr(32'h0, 32'h1C0);
    go();
    step(3);
    set_ptr(32'h0, 32'h40);
    go();
    step(30);
    cmd_ready = 1'b1;
    wait_idle("R10 idle");
    chk(c_n == 2 && a_n == 20, "R10 no restart", 64'(a_n), 64'd20);
    chk(a_log[0] == 64'h1C0, "R10 first walk", a_log[0], 64'h1C0);
    clr();
    go();
    wait_idle("R10 idle 2");
    chk(a_log[0] == 64'h1C0, "R10 pointer kept", a_log[0], 64'h1C0);
  endtask

  task automatic t_high_half();
    clr();
    cmd_ready = 1'b1;
    put_desc(32'h240, 64'h77, 64'h88, 32'd0, 64'h0, 32'h0, VLD | LST);
    set_ptr(32'h0000_0001, 32'h0000_0241);
    go();
    wait_idle("R2 idle");
    chk(a_log[0] == 64'h1_0000_0240, "R2 upper half", a_log[0], 64'h1_0000_0240);
    chk(s_log[0] == 1'b1, "R2 master select", 64'(s_log[0]), 64'd1);
    chk(n_done == 1, "R8 upper done", 64'(n_done), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_single();
    t_chain();
    t_invalid();
    t_suspend();
    t_busy_ignore();
    t_high_half();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule